// File: doc/BRIEF.md
# Block Erase and Word Program Sequencer with Suspend

This block is the internal write engine behind a flash-style command decoder. It holds a small behavioural cell array and runs two operations on it. The first is word program, which can only clear bits. The second is block erase, which always covers a whole block. The block to erase is taken from the upper address bits, so any address inside the block selects it. Pulses are modelled as fixed cycle counts, and each pulse is followed by a read-back verify.

An erase first drives every word of the block to zero, one word at a time, and verifies each one. It then applies one block-wide erase pulse and checks that every word reads all ones. A failing verify repeats its pulse up to a retry limit and then stops with an error flag. A suspend request pauses the operation at the end of the next pulse. A resume request continues from the exact step where it stopped. An active-low reset aborts any operation in flight and leaves the cells as they are at that moment.

Top module: `blkerase_seq`

## Requirements
- R1: After reset the status byte reads 0x80: bit 7 (ready) is set, and the flags for erase suspended (bit 6), erase error (bit 5), program error (bit 4) and program suspended (bit 2) are clear. All other bits always read 0.
- R2: An erase request at any address erases only the block given by address bits [AW-1:IW]. When it completes, every word of that block reads all ones, the other blocks are unchanged and the status reads 0x80.
- R3: An erase runs in this order. For each word in turn: a zeroing pulse of PROG_CYC cycles and a one-cycle zero verify. Then one erase pulse of ERASE_CYC cycles, then a one-cycle all-ones verify for each word. With no failures, ready is low for exactly BLK_WORDS*(PROG_CYC+1)+ERASE_CYC+BLK_WORDS cycles.
- R4: A program request ANDs the data into the addressed word. If the result equals the data, ready is low for exactly PROG_CYC+1 cycles.
- R5: If the program read-back differs from the data, the pulse and verify repeat. After MAX_RETRY retries the operation stops with bit 4 set (status 0x90), having spent (MAX_RETRY+1)*(PROG_CYC+1) cycles busy.
- R6: If the block stays unerased (cell_stuck high), the erase stops after MAX_RETRY retries of its erase pulse with bit 5 set (status 0xA0).
- R7: A suspend request during an erase takes effect at the end of the current or next pulse, within BLK_WORDS+ERASE_CYC+PROG_CYC+2 cycles. The status then reads 0xC0 and no cell changes while suspended.
- R8: A resume request during a suspend continues at the verify that follows the interrupted pulse. The total busy time and the final array contents match those of an uninterrupted run.
- R9: A suspend during a program reads 0x84. A suspend request that lands on the cycle in which a pulse ends takes effect on that same cycle.
- R10: Start requests while busy or suspended, suspend and resume requests while idle, and a suspend request on the cycle an operation completes all have no effect, now or on a later operation.
- R11: Driving rst_n low mid-operation returns the status to 0x80 at once and keeps whatever the cells held at that moment.
- R12: Each new start clears both error flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; aborts any operation |
| req_erase | input | 1 | One-cycle request to start a block erase |
| req_prog | input | 1 | One-cycle request to start a word program |
| req_suspend | input | 1 | One-cycle suspend request |
| req_resume | input | 1 | One-cycle resume request |
| req_addr | input | AW | Word address for program; any address in the block for erase |
| req_data | input | DATA_W | Program data |
| cell_stuck | input | 1 | Defect model: while high, erase pulses leave the cells unchanged |
| rd_addr | input | AW | Array read address |
| rd_data | output | DATA_W | Array word at rd_addr |
| status | output | 8 | Status byte: bit 7 ready, bit 6 erase suspended, bit 5 erase error, bit 4 program error, bit 2 program suspended |

## Verification
Two events can meet on the same clock edge. A suspend request can arrive on the edge where a pulse finishes, or on the edge where the last verify retires the operation. In the first case the sequencer must park at once. In the second the request must vanish, so that it does not carry over into the next operation. The bench places a suspend exactly on the fourth edge of a program pulse and expects 0x84 one cycle later. It then places a suspend on the verify edge of a passing program and expects 0x80, followed by a later program that runs its full PROG_CYC+1 cycles without parking. A behavioural model compares the status and the read port on every cycle, including around these collisions.

// File: rtl/bsq_pkg.sv
package bsq_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_ZERO, S_ZCHK, S_WIPE, S_OCHK, S_PGM, S_PCHK, S_PARK
  } seq_st_t;

  localparam int SB_READY = 7;
  localparam int SB_ESUSP = 6;
  localparam int SB_EERR  = 5;
  localparam int SB_PERR  = 4;
  localparam int SB_PSUSP = 2;

  // status byte assembled from sequencer state and sticky error flags
  function automatic logic [7:0] pack_status(seq_st_t st, seq_st_t resume_st,
                                             logic e_err, logic p_err);
    logic [7:0] s;
    s = '0;
    s[SB_READY] = (st == S_IDLE) || (st == S_PARK);
    s[SB_ESUSP] = (st == S_PARK) && ((resume_st == S_ZCHK) || (resume_st == S_OCHK));
    s[SB_PSUSP] = (st == S_PARK) && (resume_st == S_PCHK);
    s[SB_EERR]  = e_err;
    s[SB_PERR]  = p_err;
    return s;
  endfunction

  // verify step that follows a pulse step
  function automatic seq_st_t check_after(seq_st_t pulse_st);
    case (pulse_st)
      S_ZERO:  return S_ZCHK;
      S_WIPE:  return S_OCHK;
      default: return S_PCHK;
    endcase
  endfunction

  // pulse step re-issued when a verify step fails
  function automatic seq_st_t retry_of(seq_st_t chk_st);
    case (chk_st)
      S_ZCHK:  return S_ZERO;
      S_OCHK:  return S_WIPE;
      default: return S_PGM;
    endcase
  endfunction

endpackage

// File: rtl/bsq_pulse_timer.sv
module bsq_pulse_timer #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [CW-1:0] last_val,
  output logic          done
);

  logic [CW-1:0] cnt;

  assign done = run && (cnt == last_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (!run || done)  cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end

  // a pulse never finishes while the timer is idle
  p_done_needs_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(run) || (cnt == '0));

endmodule

// File: rtl/bsq_array.sv
module bsq_array #(
  parameter int N_BLK     = 4,
  parameter int BLK_WORDS = 8,
  parameter int DW        = 8
) (
  input  logic                       clk,
  input  logic                       pgm_en,
  input  logic [$clog2(N_BLK*BLK_WORDS)-1:0] pgm_addr,
  input  logic [DW-1:0]              pgm_mask,
  input  logic                       ers_en,
  input  logic [$clog2(N_BLK)-1:0]   ers_blk,
  input  logic                       ers_hold,
  input  logic [$clog2(N_BLK*BLK_WORDS)-1:0] vfy_addr,
  output logic [DW-1:0]              vfy_data,
  input  logic [$clog2(N_BLK*BLK_WORDS)-1:0] rd_addr,
  output logic [DW-1:0]              rd_data
);

  localparam int WORDS = N_BLK * BLK_WORDS;
  localparam int AW    = $clog2(WORDS);
  localparam int BW    = $clog2(N_BLK);

  logic [WORDS-1:0][DW-1:0] cells;

  // cells are deliberately not reset: an aborted operation leaves them as is
  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic [DW-1:0] cell_q;
    always_ff @(posedge clk) begin
      if (ers_en && !ers_hold && (ers_blk == BW'(w / BLK_WORDS)))
        cell_q <= '1;
      else if (pgm_en && (pgm_addr == AW'(w)))
        cell_q <= cell_q & pgm_mask;
    end
    assign cells[w] = cell_q;
  end

  assign vfy_data = cells[vfy_addr];
  assign rd_data  = cells[rd_addr];

endmodule

// File: rtl/bsq_ctrl.sv
module bsq_ctrl
  import bsq_pkg::*;
#(
  parameter int N_BLK     = 4,
  parameter int BLK_WORDS = 8,
  parameter int DW        = 8,
  parameter int PROG_CYC  = 4,
  parameter int ERASE_CYC = 6,
  parameter int MAX_RETRY = 2,
  parameter int CW        = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_erase,
  input  logic                       req_prog,
  input  logic                       req_suspend,
  input  logic                       req_resume,
  input  logic [$clog2(N_BLK*BLK_WORDS)-1:0] req_addr,
  input  logic [DW-1:0]              req_data,
  input  logic [DW-1:0]              vfy_data,
  output logic [$clog2(N_BLK*BLK_WORDS)-1:0] vfy_addr,
  input  logic                       pulse_done,
  output logic                       pulse_run,
  output logic [CW-1:0]              pulse_last,
  output logic                       pgm_en,
  output logic [$clog2(N_BLK*BLK_WORDS)-1:0] pgm_addr,
  output logic [DW-1:0]              pgm_mask,
  output logic                       ers_en,
  output logic [$clog2(N_BLK)-1:0]   ers_blk,
  output logic [7:0]                 status
);

  localparam int AW         = $clog2(N_BLK * BLK_WORDS);
  localparam int BW         = $clog2(N_BLK);
  localparam int IW         = $clog2(BLK_WORDS);
  localparam int RW         = (MAX_RETRY < 1) ? 1 : $clog2(MAX_RETRY + 1);
  localparam int SUSP_BOUND = BLK_WORDS + ERASE_CYC + PROG_CYC + 2;
  localparam int LW         = $clog2(SUSP_BOUND + 2);

  function automatic logic [BW-1:0] blk_of(logic [AW-1:0] a);
    return a[AW-1:IW];
  endfunction

  function automatic logic [AW-1:0] word_of(logic [BW-1:0] b, logic [IW-1:0] i);
    return {b, i};
  endfunction

  seq_st_t         st, resume_st;
  logic [IW-1:0]   idx;
  logic [BW-1:0]   blk;
  logic [AW-1:0]   paddr;
  logic [DW-1:0]   pdata;
  logic [RW-1:0]   retry;
  logic            susp_pend, e_err, p_err;

  // named events
  logic busy_st, in_check, expect_ok, last_word, retries_spent;
  logic ev_park, ev_finish;
  logic [DW-1:0] expect_val;

  assign busy_st       = !(st inside {S_IDLE, S_PARK});
  assign in_check      = st inside {S_ZCHK, S_OCHK, S_PCHK};
  assign last_word     = (idx == IW'(BLK_WORDS - 1));
  assign retries_spent = (retry == RW'(MAX_RETRY));
  assign expect_val    = (st == S_ZCHK) ? '0 : (st == S_OCHK) ? '1 : pdata;
  assign vfy_addr      = (st == S_PCHK) ? paddr : word_of(blk, idx);
  assign expect_ok     = (vfy_data == expect_val);
  assign ev_park       = pulse_done && (susp_pend || req_suspend);
  assign ev_finish     = in_check && ((expect_ok && ((st == S_PCHK) || (st == S_OCHK && last_word)))
                                      || (!expect_ok && retries_spent));

  assign pulse_run  = st inside {S_ZERO, S_WIPE, S_PGM};
  assign pulse_last = (st == S_WIPE) ? CW'(ERASE_CYC - 1) : CW'(PROG_CYC - 1);
  assign pgm_en     = pulse_done && (st inside {S_ZERO, S_PGM});
  assign pgm_addr   = (st == S_PGM) ? paddr : word_of(blk, idx);
  assign pgm_mask   = (st == S_PGM) ? pdata : '0;
  assign ers_en     = pulse_done && (st == S_WIPE);
  assign ers_blk    = blk;
  assign status     = pack_status(st, resume_st, e_err, p_err);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;  resume_st <= S_IDLE;
      idx <= '0;  blk <= '0;  paddr <= '0;  pdata <= '0;  retry <= '0;
      susp_pend <= 1'b0;  e_err <= 1'b0;  p_err <= 1'b0;
    end else begin
      if (busy_st && req_suspend) susp_pend <= 1'b1;
      case (st)
        S_IDLE: begin
          if (req_erase) begin
            blk <= blk_of(req_addr);  idx <= '0;  retry <= '0;
            e_err <= 1'b0;  p_err <= 1'b0;  st <= S_ZERO;
          end else if (req_prog) begin
            paddr <= req_addr;  pdata <= req_data;  retry <= '0;
            e_err <= 1'b0;  p_err <= 1'b0;  st <= S_PGM;
          end
        end
        S_ZERO, S_WIPE, S_PGM: begin
          if (pulse_done) begin
            if (ev_park) begin
              resume_st <= check_after(st);  susp_pend <= 1'b0;  st <= S_PARK;
            end else begin
              st <= check_after(st);
            end
          end
        end
        S_ZCHK, S_OCHK, S_PCHK: begin
          if (expect_ok) begin
            retry <= '0;
            if (ev_finish) begin
              st <= S_IDLE;  susp_pend <= 1'b0;
            end else if (st == S_ZCHK && last_word) begin
              idx <= '0;  st <= S_WIPE;
            end else begin
              idx <= idx + 1'b1;
              st  <= (st == S_ZCHK) ? S_ZERO : S_OCHK;
            end
          end else if (retries_spent) begin
            st <= S_IDLE;  susp_pend <= 1'b0;
            if (st == S_PCHK) p_err <= 1'b1;
            else              e_err <= 1'b1;
          end else begin
            retry <= retry + 1'b1;
            st    <= retry_of(st);
          end
        end
        S_PARK: if (req_resume) st <= resume_st;
        default: st <= S_IDLE;
      endcase
    end
  end

  // latency watch for a pending suspend
  logic [LW-1:0] lat_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      lat_cnt <= '0;
    else if (susp_pend && busy_st)   lat_cnt <= (lat_cnt == '1) ? lat_cnt : lat_cnt + 1'b1;
    else                             lat_cnt <= '0;
  end

  p_susp_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lat_cnt <= LW'(SUSP_BOUND));

  p_resume_target_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PARK && req_resume) |=> (st == $past(resume_st)));

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && !req_erase && !req_prog) |=> (st == S_IDLE));

  p_perr_at_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(p_err) |-> (st == S_IDLE));

  p_start_clears_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_st) |-> !e_err && !p_err);

endmodule

// File: rtl/blkerase_seq.sv
module blkerase_seq #(
  parameter int N_BLK     = 4,
  parameter int BLK_WORDS = 8,
  parameter int DATA_W    = 8,
  parameter int PROG_CYC  = 4,
  parameter int ERASE_CYC = 6,
  parameter int MAX_RETRY = 2,
  parameter int AW        = $clog2(N_BLK * BLK_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_erase,
  input  logic              req_prog,
  input  logic              req_suspend,
  input  logic              req_resume,
  input  logic [AW-1:0]     req_addr,
  input  logic [DATA_W-1:0] req_data,
  input  logic              cell_stuck,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [7:0]        status
);

  localparam int BW    = $clog2(N_BLK);
  localparam int MAXC  = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int CW    = (MAXC < 2) ? 1 : $clog2(MAXC);

  logic              pulse_run, pulse_done;
  logic [CW-1:0]     pulse_last;
  logic              a_pgm_en, a_ers_en;
  logic [AW-1:0]     a_pgm_addr, a_vfy_addr;
  logic [DATA_W-1:0] a_pgm_mask, a_vfy_data;
  logic [BW-1:0]     a_ers_blk;

  bsq_ctrl #(
    .N_BLK(N_BLK), .BLK_WORDS(BLK_WORDS), .DW(DATA_W), .PROG_CYC(PROG_CYC),
    .ERASE_CYC(ERASE_CYC), .MAX_RETRY(MAX_RETRY), .CW(CW)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_erase(req_erase), .req_prog(req_prog),
    .req_suspend(req_suspend), .req_resume(req_resume),
    .req_addr(req_addr), .req_data(req_data),
    .vfy_data(a_vfy_data), .vfy_addr(a_vfy_addr),
    .pulse_done(pulse_done), .pulse_run(pulse_run), .pulse_last(pulse_last),
    .pgm_en(a_pgm_en), .pgm_addr(a_pgm_addr), .pgm_mask(a_pgm_mask),
    .ers_en(a_ers_en), .ers_blk(a_ers_blk),
    .status(status)
  );

  bsq_pulse_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(pulse_run), .last_val(pulse_last), .done(pulse_done)
  );

  bsq_array #(.N_BLK(N_BLK), .BLK_WORDS(BLK_WORDS), .DW(DATA_W)) u_array (
    .clk(clk),
    .pgm_en(a_pgm_en), .pgm_addr(a_pgm_addr), .pgm_mask(a_pgm_mask),
    .ers_en(a_ers_en), .ers_blk(a_ers_blk), .ers_hold(cell_stuck),
    .vfy_addr(a_vfy_addr), .vfy_data(a_vfy_data),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  // no cell write may be issued while a suspend flag is showing
  p_frozen_susp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (status[6] || status[2]) |-> !(a_pgm_en || a_ers_en));

endmodule

// File: tb/test_blkerase_seq.sv
`timescale 1ns/1ps
module test_blkerase_seq;

  localparam int N_BLK = 4, BLK_WORDS = 8, DW = 8;
  localparam int PROG_CYC = 4, ERASE_CYC = 6, MAX_RETRY = 2;
  localparam int WORDS = N_BLK * BLK_WORDS, AW = 5;
  localparam int ERASE_BUSY = BLK_WORDS * (PROG_CYC + 1) + ERASE_CYC + BLK_WORDS;
  localparam int SUSP_BOUND = BLK_WORDS + ERASE_CYC + PROG_CYC + 2;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          req_erase = 0, req_prog = 0, req_suspend = 0, req_resume = 0;
  logic [AW-1:0] req_addr = '0, rd_addr = '0;
  logic [DW-1:0] req_data = '0, rd_data;
  logic          cell_stuck = 0;
  logic [7:0]    status;

  blkerase_seq i_blkerase_seq (
    .clk(clk), .rst_n(rst_n), .req_erase(req_erase), .req_prog(req_prog),
    .req_suspend(req_suspend), .req_resume(req_resume), .req_addr(req_addr),
    .req_data(req_data), .cell_stuck(cell_stuck), .rd_addr(rd_addr),
    .rd_data(rd_data), .status(status)
  );

  int    n_chk = 0, n_fail = 0;
  string cur_req = "R1";
  bit    finished = 0;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference ----------------
  // phases: 0 idle, 1 zeroing pulse, 2 zero check, 3 wipe pulse,
  //         4 ones check, 5 write pulse, 6 write check, 7 parked
  int m_ph = 0, m_sav = 0, m_cnt = 0, m_ret = 0, m_blk = 0, m_idx = 0;
  int m_pa = 0, m_pd = 0;
  bit m_pend = 0, m_ee = 0, m_ep = 0, m_hon;
  int m_mem [WORDS];
  bit m_known [WORDS];
  int m_w, m_exp, m_len;

  function automatic int model_status();
    int s = 0;
    if (m_ph == 0 || m_ph == 7) s += 'h80;
    if (m_ph == 7 && (m_sav == 2 || m_sav == 4)) s += 'h40;
    if (m_ph == 7 && m_sav == 6) s += 'h04;
    if (m_ee) s += 'h20;
    if (m_ep) s += 'h10;
    return s;
  endfunction

  initial for (int i = 0; i < WORDS; i++) begin m_mem[i] = 0; m_known[i] = 0; end

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_sav = 0; m_cnt = 0; m_ret = 0; m_pend = 0; m_ee = 0; m_ep = 0;
    end else begin
      m_hon = m_pend || req_suspend;
      if (m_ph != 0 && m_ph != 7 && req_suspend) m_pend = 1;
      case (m_ph)
        0: if (req_erase) begin
             m_blk = req_addr / BLK_WORDS; m_idx = 0; m_ret = 0; m_ee = 0; m_ep = 0; m_cnt = 0; m_ph = 1;
           end else if (req_prog) begin
             m_pa = req_addr; m_pd = req_data; m_ret = 0; m_ee = 0; m_ep = 0; m_cnt = 0; m_ph = 5;
           end
        1, 3, 5: begin
          m_len = (m_ph == 3) ? ERASE_CYC : PROG_CYC;
          m_cnt++;
          if (m_cnt == m_len) begin
            m_cnt = 0;
            if (m_ph == 1) begin
              m_w = m_blk * BLK_WORDS + m_idx; m_mem[m_w] = 0; m_known[m_w] = 1;
            end else if (m_ph == 3) begin
              if (!cell_stuck)
                for (int k = 0; k < BLK_WORDS; k++) begin
                  m_mem[m_blk*BLK_WORDS+k] = 255; m_known[m_blk*BLK_WORDS+k] = 1;
                end
            end else begin
              m_mem[m_pa] = m_mem[m_pa] & m_pd;
            end
            if (m_hon) begin m_sav = m_ph + 1; m_pend = 0; m_ph = 7; end
            else m_ph = m_ph + 1;
          end
        end
        2, 4, 6: begin
          m_w   = (m_ph == 6) ? m_pa : m_blk * BLK_WORDS + m_idx;
          m_exp = (m_ph == 2) ? 0 : (m_ph == 4) ? 255 : m_pd;
          if (m_mem[m_w] == m_exp) begin
            m_ret = 0;
            if (m_ph == 6 || (m_ph == 4 && m_idx == BLK_WORDS-1)) begin m_ph = 0; m_pend = 0; end
            else if (m_ph == 2 && m_idx == BLK_WORDS-1) begin m_idx = 0; m_ph = 3; end
            else begin m_idx++; if (m_ph == 2) m_ph = 1; end
          end else if (m_ret == MAX_RETRY) begin
            if (m_ph == 6) m_ep = 1; else m_ee = 1;
            m_ph = 0; m_pend = 0;
          end else begin
            m_ret++; m_ph = m_ph - 1;
          end
        end
        7: if (req_resume) m_ph = m_sav;
        default: m_ph = 0;
      endcase
    end
    #1;
    chk({cur_req, " per-cycle status"}, int'(status), model_status());
    if (m_known[rd_addr]) chk({cur_req, " per-cycle rd_data"}, int'(rd_data), m_mem[rd_addr]);
  end

  // ---------------- stimulus helpers ----------------
  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic start_erase(int a, bit stk);
    @(negedge clk); cell_stuck = stk; req_addr = AW'(a); req_erase = 1;
    @(negedge clk); req_erase = 0;
  endtask

  task automatic start_prog(int a, int d);
    @(negedge clk); req_addr = AW'(a); req_data = DW'(d); req_prog = 1;
    @(negedge clk); req_prog = 0;
  endtask

  task automatic do_suspend();
    @(negedge clk); req_suspend = 1;
    @(negedge clk); req_suspend = 0;
  endtask

  task automatic do_resume();
    @(negedge clk); req_resume = 1;
    @(negedge clk); req_resume = 0;
  endtask

  task automatic wait_ready(output int n);
    n = 0;
    while (status[7] == 1'b0) begin n++; @(negedge clk); end
  endtask

  task automatic rd_chk(int a, int e, string tag);
    @(negedge clk); rd_addr = AW'(a);
    #1 chk(tag, int'(rd_data), e);
  endtask

  // ---------------- scenarios ----------------
  initial begin
    int n, m;
    cyc(3);
    rst_n = 1'b1;
    #1 chk("R1 status after reset", int'(status), 'h80);

    cur_req = "R3";
    for (int b = 0; b < N_BLK; b++) begin
      rd_addr = AW'(b * BLK_WORDS + 2);
      start_erase(b * BLK_WORDS + (7 - b), 0);
      wait_ready(n);
      chk("R3 erase busy cycles", n, ERASE_BUSY);
      chk("R2 status after erase", int'(status), 'h80);
    end
    for (int i = 0; i < WORDS; i++) rd_chk(i, 'hFF, "R2 erased word");

    cur_req = "R4";
    start_prog(3, 'h5A); wait_ready(n);
    chk("R4 program busy cycles", n, PROG_CYC + 1);
    rd_chk(3, 'h5A, "R4 programmed word");
    rd_chk(2, 'hFF, "R2 neighbour untouched");

    cur_req = "R5";
    start_prog(3, 'hFF); wait_ready(n);
    chk("R5 failing program busy cycles", n, (MAX_RETRY + 1) * (PROG_CYC + 1));
    chk("R5 program error status", int'(status), 'h90);
    rd_chk(3, 'h5A, "R5 word keeps old value");

    cur_req = "R12";
    start_prog(9, 'h0F); wait_ready(n);
    chk("R12 error cleared by new start", int'(status), 'h80);
    rd_chk(9, 'h0F, "R4 second program");

    cur_req = "R6";
    start_erase(12, 1); wait_ready(n);
    chk("R6 stuck erase busy cycles", n, BLK_WORDS*(PROG_CYC+1) + (MAX_RETRY+1)*(ERASE_CYC+1));
    chk("R6 erase error status", int'(status), 'hA0);
    rd_chk(9, 'h00, "R6 block left zeroed");
    cell_stuck = 0;
    start_erase(13, 0); wait_ready(n);
    chk("R12 erase error cleared", int'(status), 'h80);
    rd_chk(9, 'hFF, "R2 block erased after retry");

    cur_req = "R7";
    for (int i = 16; i < 20; i++) begin start_prog(i, i * 7); wait_ready(n); end
    rd_addr = AW'(17);
    start_erase(21, 0);
    n = 0;
    repeat (6) begin n++; @(negedge clk); end
    req_suspend = 1; @(negedge clk); req_suspend = 0;
    m = 0;
    while (status[6] == 1'b0 && m < 4 * SUSP_BOUND) begin
      if (status[7] == 1'b0) n++;
      m++; @(negedge clk);
    end
    if (m > SUSP_BOUND) chk("R7 suspend latency within bound", m, SUSP_BOUND);
    else                chk("R7 suspend latency within bound", 1, 1);
    chk("R7 erase suspended status", int'(status), 'hC0);
    cur_req = "R10";
    start_prog(0, 'h00);
    cyc(10);
    chk("R10 start ignored while suspended", int'(status), 'hC0);
    rd_chk(0, 'hFF, "R10 ignored program left word");
    cur_req = "R8";
    do_resume();
    wait_ready(m);
    chk("R8 busy cycles unchanged by suspend", n + m + 1, ERASE_BUSY);
    chk("R8 status after resumed erase", int'(status), 'h80);
    for (int i = 16; i < 24; i++) rd_chk(i, 'hFF, "R8 resumed block erased");

    cur_req = "R9";
    start_prog(24, 'h33);
    cyc(2);
    do_suspend();
    chk("R9 suspend on pulse-end cycle", int'(status), 'h84);
    do_resume(); wait_ready(n);
    rd_chk(24, 'h33, "R9 program after resume");
    start_prog(24, 'h30);
    cyc(3);
    do_suspend();
    chk("R10 suspend on completion cycle", int'(status), 'h80);
    start_prog(26, 'h77); wait_ready(n);
    chk("R10 no stale suspend", n, PROG_CYC + 1);
    rd_chk(24, 'h30, "R10 completed program");

    cur_req = "R10";
    do_suspend(); do_resume(); cyc(3);
    chk("R10 idle suspend/resume ignored", int'(status), 'h80);
    start_erase(30, 0);
    cyc(3);
    start_prog(1, 'h00);
    wait_ready(n);
    rd_chk(1, 'hFF, "R10 program during erase ignored");
    rd_chk(26, 'hFF, "R2 block three erased");

    cur_req = "R11";
    start_erase(2, 0);
    cyc(11);
    rst_n = 1'b0;
    cyc(2);
    #1 chk("R11 status during reset", int'(status), 'h80);
    @(negedge clk); rst_n = 1'b1;
    cyc(2);
    chk("R11 idle after abort", int'(status), 'h80);
    rd_chk(0, 'h00, "R11 zeroed word kept");
    rd_chk(7, 'hFF, "R11 untouched word kept");
    start_erase(5, 0); wait_ready(n);
    rd_chk(3, 'hFF, "R11 erase after abort");

    cyc(4);
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule